// File: doc/BRIEF.md
# Bi-Quinary Decade Prescaler

This block is the first and fastest decade of a counting chain. Each accepted count event flips a single divide-by-two stage. Every second event, that stage advances a five-position one-hot ring. Together the two divide by ten. The BCD digit is not kept in a binary register. Encoding logic forms it from the ring position and the half bit, as twice the position plus the half bit.

When the digit wraps from nine back to zero, the block raises a one-cycle carry strobe. The following decade counts on that strobe. The same decade can be placed again in a reference divider chain without change.

Count events come in as a strobe that is sampled on the clock. The strobe is accepted only while the enable is high. A synchronous clear returns the decade to zero and wins over counting. The ring holds exactly one hot bit. Any other pattern is forced back to position zero.

Top module: `biq_decade`

## Requirements
- R1: While reset is asserted and after its release with no count, `digit_o` reads 0 and `carry_o` reads 0.
- R2: Each cycle in which `cnt_i` and `en_i` are both 1 and `clr_i` is 0 advances `digit_o` by one, modulo ten, on the next clock edge. The sequence is 0,1,...,9,0.
- R3: `digit_o[0]` is the divide-by-two bit and flips on every accepted event. `digit_o[3:1]` is the ring position (0 to 4) and advances on every accepted event that finds `digit_o[0]` at 1.
- R4: `carry_o` is 1 for exactly the one cycle after an accepted event taken at digit 9. In that cycle `digit_o` reads 0. In every other cycle `carry_o` is 0.
- R5: With `en_i` at 0 and `clr_i` at 0, the digit holds and `carry_o` is 0, whatever the value of `cnt_i`.
- R6: With `cnt_i` at 0 and `clr_i` at 0, the digit holds and `carry_o` is 0, whatever the value of `en_i`.
- R7: When `clr_i` is 1, the next cycle shows digit 0 and `carry_o` at 0. This holds even if an accepted event at digit 9 falls in the same cycle.
- R8: The ring always holds exactly one hot bit. A pattern that is not one-hot is replaced by position zero on the next edge.
- R9: `digit_o` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_i | input | 1 | Count event strobe, one event per high cycle |
| en_i | input | 1 | Count enable |
| clr_i | input | 1 | Synchronous clear, overrides counting |
| digit_o | output | DIG_W (4) | BCD digit, twice the ring position plus the half bit |
| carry_o | output | 1 | One-cycle strobe on the wrap from 9 to 0 |

## Verification
The wrap carry and the synchronous clear can fall in the same cycle. This happens when an accepted event arrives at digit 9 while `clr_i` is high. The bench provokes it in an exhaustive sweep. The sweep walks the decade to every starting digit and applies all eight combinations of count, enable and clear. Each outcome is judged against an arithmetic modulo-ten model in which clear takes precedence. At digit 9 with all three inputs high, the model therefore expects digit 0 with no carry.

// File: rtl/biq_pkg.sv
package biq_pkg;

  // Per-stage command shared by the half stage and the ring.
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_STEP  = 2'd1,
    CMD_CLEAR = 2'd2
  } biq_cmd_e;

endpackage

// File: rtl/biq_half.sv
module biq_half
  import biq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  biq_cmd_e cmd_i,
  output logic     half_o
);

  logic half_q;
  logic half_d;

  always_comb begin
    half_d = half_q;
    case (cmd_i)
      CMD_CLEAR: half_d = 1'b0;
      CMD_STEP:  half_d = ~half_q;
      default:   half_d = half_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign half_o = half_q;

  // R3: an accepted step flips the divide-by-two bit
  p_half_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_STEP) |=> (half_q == !$past(half_q)));

  // R7: clear drives the half bit low
  p_half_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_CLEAR) |=> !half_q);

endmodule

// File: rtl/biq_ring.sv
module biq_ring
  import biq_pkg::*;
#(
  parameter int RING_LEN = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  biq_cmd_e            cmd_i,
  output logic [RING_LEN-1:0] ring_o,
  output logic                last_o
);

  localparam logic [RING_LEN-1:0] HOME = {{(RING_LEN-1){1'b0}}, 1'b1};

  logic [RING_LEN-1:0] ring_q;
  logic [RING_LEN-1:0] ring_d;
  logic                legal;

  // exactly one hot bit
  always_comb begin
    int hot;
    hot = 0;
    for (int i = 0; i < RING_LEN; i++) begin
      if (ring_q[i]) hot = hot + 1;
    end
    legal = (hot == 1);
  end

  always_comb begin
    ring_d = ring_q;
    if (cmd_i == CMD_CLEAR || !legal) begin
      ring_d = HOME;
    end else if (cmd_i == CMD_STEP) begin
      ring_d = {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= HOME;
    else        ring_q <= ring_d;
  end

  assign ring_o = ring_q;
  assign last_o = ring_q[RING_LEN-1];

  // R8: the ring carries a single hot bit
  p_ring_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ring_q));

  // R6: no step and no clear leaves a legal ring untouched
  p_ring_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_HOLD && $onehot(ring_q)) |=> $stable(ring_q));

  // R7: clear returns the ring to position zero
  p_ring_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_CLEAR) |=> (ring_q == HOME));

endmodule

// File: rtl/biq_encode.sv
module biq_encode #(
  parameter int RING_LEN = 5,
  parameter int DIG_W    = 4
) (
  input  logic [RING_LEN-1:0] ring_i,
  input  logic                half_i,
  output logic [DIG_W-1:0]    digit_o
);

  localparam int POS_W = DIG_W - 1;

  logic [POS_W-1:0] pos;

  // OR together the indices of hot bits; a single hot bit yields its index
  always_comb begin
    pos = '0;
    for (int i = 0; i < RING_LEN; i++) begin
      if (ring_i[i]) pos = pos | POS_W'(i);
    end
  end

  assign digit_o = {pos, half_i};

endmodule

// File: rtl/biq_decade.sv
module biq_decade
  import biq_pkg::*;
#(
  parameter int RING_LEN = 5,
  parameter int DIG_W    = $clog2(RING_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             carry_o
);

  localparam int MODULUS = 2 * RING_LEN;

  logic                accept;
  logic                half_q;
  logic [RING_LEN-1:0] ring_q;
  logic                ring_last;
  logic                wrap;
  biq_cmd_e            half_cmd;
  biq_cmd_e            ring_cmd;
  logic                carry_q;
  logic                carry_d;

  assign accept = cnt_i & en_i;

  always_comb begin
    if (clr_i)       half_cmd = CMD_CLEAR;
    else if (accept) half_cmd = CMD_STEP;
    else             half_cmd = CMD_HOLD;
  end

  always_comb begin
    if (clr_i)                 ring_cmd = CMD_CLEAR;
    else if (accept && half_q) ring_cmd = CMD_STEP;
    else                       ring_cmd = CMD_HOLD;
  end

  biq_half u_half (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (half_cmd),
    .half_o (half_q)
  );

  biq_ring #(.RING_LEN(RING_LEN)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (ring_cmd),
    .ring_o (ring_q),
    .last_o (ring_last)
  );

  biq_encode #(.RING_LEN(RING_LEN), .DIG_W(DIG_W)) u_encode (
    .ring_i  (ring_q),
    .half_i  (half_q),
    .digit_o (digit_o)
  );

  assign wrap = accept & half_q & ring_last;

  always_comb begin
    carry_d = wrap & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carry_o = carry_q;

  // R9: digit stays within the decade
  p_digit_bcd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(digit_o) < MODULUS));

  // R4: carry appears only with a zero digit
  p_carry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (digit_o == '0));

  // R4: carry never lasts two cycles
  p_carry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  // R5: disabled decade holds and stays quiet
  p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(digit_o) && !carry_o));

  // R7: clear wins over counting
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (digit_o == '0 && !carry_o));

  // R2: an accepted event changes the digit
  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr_i) |=> (digit_o != $past(digit_o)));

endmodule

// File: tb/test_biq_decade.sv
module test_biq_decade;

  logic       clk;
  logic       rst_n;
  logic       cnt_i;
  logic       en_i;
  logic       clr_i;
  logic [3:0] digit_o;
  logic       carry_o;

  int checks;
  int errors;
  int exp_d;
  int exp_c;
  bit done;

  biq_decade i_biq_decade (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_i   (cnt_i),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .digit_o (digit_o),
    .carry_o (carry_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Applies one cycle of stimulus at a falling edge and advances the model.
  task automatic tick(input bit c, input bit e, input bit k);
    cnt_i = c; en_i = e; clr_i = k;
    @(posedge clk);
    if (k) begin
      exp_d = 0; exp_c = 0;
    end else if (c && e) begin
      exp_c = (exp_d == 9) ? 1 : 0;
      exp_d = (exp_d + 1) % 10;
    end else begin
      exp_c = 0;
    end
    @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    chk(int'(digit_o), exp_d, {tag, " digit"});
    chk(int'(carry_o), exp_c, {tag, " carry"});
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    exp_d = 0; exp_c = 0;
    cnt_i = 0; en_i = 0; clr_i = 0;
    rst_n = 1'b0;
    #1;
    chk(int'(digit_o), 0, "R1 reset digit");
    chk(int'(carry_o), 0, "R1 reset carry");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");

    // R2 R3 R4: two full turns of the decade
    for (int n = 0; n < 20; n++) begin
      tick(1, 1, 0);
      check_state("R2 sequence");
      chk(int'(digit_o[0]), exp_d % 2, "R3 half bit");
      chk(int'(digit_o[3:1]), exp_d / 2, "R3 ring position");
      chk(int'(digit_o <= 9), 1, "R9 range");
    end

    // R5: enable low holds with events present
    for (int n = 0; n < 3; n++) tick(1, 1, 0);
    for (int n = 0; n < 4; n++) begin
      tick(1, 0, 0);
      check_state("R5 enable low");
    end
    // R6: no event holds with enable high
    for (int n = 0; n < 4; n++) begin
      tick(0, 1, 0);
      check_state("R6 no event");
    end

    // R7: clear at digit 9 together with an accepted event
    tick(0, 0, 1);
    for (int n = 0; n < 9; n++) tick(1, 1, 0);
    chk(int'(digit_o), 9, "R7 setup at nine");
    tick(1, 1, 1);
    check_state("R7 clear beats wrap");
    chk(int'(carry_o), 0, "R7 no carry on clear");

    // R4: carry is a single cycle
    for (int n = 0; n < 10; n++) tick(1, 1, 0);
    chk(int'(carry_o), 1, "R4 carry raised");
    tick(0, 1, 0);
    chk(int'(carry_o), 0, "R4 carry dropped");

    // Exhaustive sweep: every start digit times every input combination
    for (int s = 0; s < 10; s++) begin
      for (int m = 0; m < 8; m++) begin
        tick(0, 0, 1);
        for (int n = 0; n < s; n++) tick(1, 1, 0);
        tick(m[0], m[1], m[2]);
        check_state("R2 R4 R5 R6 R7 sweep");
        chk(int'(digit_o <= 9), 1, "R9 sweep range");
      end
    end

    // Mixed pattern from an arithmetic sequence
    begin
      int v;
      v = 7;
      for (int n = 0; n < 300; n++) begin
        v = (v * 13 + 5) % 64;
        tick(v[0] | v[3], v[1] | v[4], (v % 17) == 0);
        check_state("R2 R4 R7 mixed");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule